// File: doc/BRIEF.md
# Voltage and Temperature Conversion Scheduler

This block decides when an external measurement converter runs and which quantity it measures. A 2-bit operating mode selects what it does. Sleep issues nothing. Each manual mode issues one conversion of a single quantity. Automatic mode issues a voltage conversion followed by a temperature conversion once every scheduling period. The period is counted in ticks of a slow timebase.

For each conversion the block pulses a start request and holds a channel select (0 = voltage, 1 = temperature). It also raises an activity line that keeps the converter awake. It then waits for the converter's done strobe. On that strobe it captures the 16-bit result into the register for that channel and drops the activity line so the converter goes back to sleep. In the same cycle as the capture it emits a one-cycle update pulse, tagged with the channel, for a downstream limit monitor.

The mode value is written through `modeIn` qualified by `modeWrite`. A write of a manual value is itself the trigger, so writing the same manual value again queues another conversion.

Top module: `conv_scheduler`

## Requirements
- R1: After reset the mode is sleep (00), `convStart`, `convActive` and `updStrobe` are 0, and both result registers read 0.
- R2: In mode 00 no `convStart` is issued, whatever ticks arrive.
- R3: Writing mode 10 issues one `convStart` with `convSel`=0 in the cycle after the write edge. When the conversion is done, the block issues nothing more.
- R4: Writing mode 01 issues one `convStart` with `convSel`=1 in the cycle after the write edge. When the conversion is done, the block issues nothing more.
- R5: Rewriting the current manual mode value queues exactly one more conversion of the same channel.
- R6: Writing mode 11 from another mode starts a voltage conversion in the cycle after the write edge. When the voltage done strobe is seen, the temperature start (`convSel`=1) follows in the very next cycle.
- R7: In mode 11, after a pair has been started, the next pair starts one cycle after the PERIOD_TICKS-th tick counted from the mode 11 write, and not before.
- R8: `voltResult` changes only when a voltage conversion's done strobe is seen, and `tempResult` only when a temperature conversion's done strobe is seen. A `convDone` while no conversion is active changes nothing.
- R9: In the cycle after a done strobe, `updStrobe` is high for exactly one cycle, `updChan` names the channel (0 = voltage, 1 = temperature), and the captured value is visible on that channel's result port.
- R10: `convActive` is high from the start cycle until the done strobe. It is low in the following cycle unless the temperature half of an automatic pair starts in that cycle.
- R11: A mode write during an active conversion does not abort it: its result is still stored. An automatic pair whose mode was left before its voltage done strobe issues no temperature conversion.
- R12: `convStart` lasts one cycle, is only high while `convActive` is high, and never occurs while an earlier conversion still awaits its done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 2 | Mode value: 00 sleep, 01 temperature once, 10 voltage once, 11 automatic |
| modeWrite | input | 1 | One-cycle strobe that loads `modeIn` |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| convDone | input | 1 | Converter finished; `convData` is valid |
| convData | input | DATA_W | Converter result |
| convStart | output | 1 | One-cycle start request to the converter |
| convSel | output | 1 | Channel of the current conversion, 0 voltage, 1 temperature |
| convActive | output | 1 | Converter awake; low means sleep |
| voltResult | output | DATA_W | Last voltage result |
| tempResult | output | DATA_W | Last temperature result |
| updStrobe | output | 1 | One-cycle pulse when a result register loads |
| updChan | output | 1 | Channel that loaded with `updStrobe` |

## Verification
A table of manual writes alternates the voltage and temperature modes with data at zero, all ones and mixed values. This shows that each result lands only in its own channel's register and that each write yields exactly one start. One entry repeats the previous manual value, which separates a write-triggered scheduler from one that only reacts to a change of mode. Automatic runs check the immediate voltage-then-temperature sequence, and a tick count one short of the period followed by the final tick, which exposes an off-by-one period counter. A done strobe while idle and a mode exit in the middle of a pair show that stray or interrupted handshakes neither corrupt results nor issue a dangling temperature start.

// File: rtl/convsched_pkg.sv
package convsched_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_TEMP  = 2'b01,
    MODE_VOLT  = 2'b10,
    MODE_AUTO  = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_VOLT,
    ST_TEMP
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;
    logic cntClear;
    logic loadVolt;
    logic loadTemp;
  } dpStrobeT;

  localparam logic CH_VOLT = 1'b0;
  localparam logic CH_TEMP = 1'b1;

endpackage

// File: rtl/convsched_dpath.sv
module convsched_dpath
  import convsched_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int PERIOD_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          ctl,
  input  logic              tick,
  input  logic [DATA_W-1:0] convData,
  output logic              periodHit,
  output logic [DATA_W-1:0] voltResult,
  output logic [DATA_W-1:0] tempResult,
  output logic              updStrobe,
  output logic              updChan
);

  localparam int CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_TICKS - 1);
  localparam int NUM_CH = 2;

  logic [CNT_W-1:0] tickCnt;
  logic [NUM_CH-1:0] loadVec;
  logic [DATA_W-1:0] resReg [NUM_CH];

  // period timebase: counts ticks while automatic mode is in force
  assign periodHit = ctl.cntRun && !ctl.cntClear && tick && (tickCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (ctl.cntClear || !ctl.cntRun) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= (tickCnt == CNT_LAST) ? '0 : tickCnt + 1'b1;
    end
  end

  // one result register per channel, index = channel code
  assign loadVec = {ctl.loadTemp, ctl.loadVolt};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resReg[ch] <= '0;
      end else if (loadVec[ch]) begin
        resReg[ch] <= convData;
      end
    end
  end

  assign voltResult = resReg[CH_VOLT];
  assign tempResult = resReg[CH_TEMP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updStrobe <= 1'b0;
      updChan   <= CH_VOLT;
    end else begin
      updStrobe <= |loadVec;
      updChan   <= ctl.loadTemp;
    end
  end

endmodule

// File: rtl/convsched_ctrl.sv
module convsched_ctrl
  import convsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       modeWrite,
  input  logic       convDone,
  input  logic       periodHit,
  output logic       convStart,
  output logic       convSel,
  output logic       convActive,
  output dpStrobeT   ctl
);

  modeT  modeReg;
  modeT  modeNew;
  stateT state;
  logic  pendMan;    // a manual conversion is queued
  logic  pendCh;     // its channel
  logic  autoDue;    // an automatic pair is queued
  logic  pairRun;    // current conversion belongs to an automatic pair
  logic  enterAuto;

  assign modeNew   = modeT'(modeIn);
  assign enterAuto = modeWrite && (modeNew == MODE_AUTO) && (modeReg != MODE_AUTO);

  assign convActive   = (state != ST_IDLE);
  assign ctl.cntRun   = (modeReg == MODE_AUTO);
  assign ctl.cntClear = enterAuto;
  assign ctl.loadVolt = (state == ST_VOLT) && convDone;
  assign ctl.loadTemp = (state == ST_TEMP) && convDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= MODE_SLEEP;
      state     <= ST_IDLE;
      pendMan   <= 1'b0;
      pendCh    <= CH_VOLT;
      autoDue   <= 1'b0;
      pairRun   <= 1'b0;
      convStart <= 1'b0;
      convSel   <= CH_VOLT;
    end else begin
      convStart <= 1'b0;

      // conversion sequencing
      case (state)
        ST_IDLE: begin
          if (pendMan) begin
            state     <= pendCh ? ST_TEMP : ST_VOLT;
            convStart <= 1'b1;
            convSel   <= pendCh;
            pairRun   <= 1'b0;
            pendMan   <= 1'b0;
          end else if (autoDue && modeReg == MODE_AUTO) begin
            state     <= ST_VOLT;
            convStart <= 1'b1;
            convSel   <= CH_VOLT;
            pairRun   <= 1'b1;
            autoDue   <= 1'b0;
          end
        end
        ST_VOLT: begin
          if (convDone) begin
            if (pairRun && modeReg == MODE_AUTO) begin
              state     <= ST_TEMP;
              convStart <= 1'b1;
              convSel   <= CH_TEMP;
            end else begin
              state   <= ST_IDLE;
              pairRun <= 1'b0;
            end
          end
        end
        ST_TEMP: begin
          if (convDone) begin
            state   <= ST_IDLE;
            pairRun <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (periodHit) autoDue <= 1'b1;

      // mode writes override queue updates made above
      if (modeWrite) begin
        modeReg <= modeNew;
        case (modeNew)
          MODE_VOLT, MODE_TEMP: begin
            pendMan <= 1'b1;
            pendCh  <= (modeNew == MODE_TEMP);
            autoDue <= 1'b0;
          end
          MODE_AUTO: begin
            pendMan <= 1'b0;
            if (enterAuto) autoDue <= 1'b1;
          end
          default: begin
            pendMan <= 1'b0;
            autoDue <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
  import convsched_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int TICK_HZ      = 32,
  parameter int PERIOD_SEC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeIn,
  input  logic              modeWrite,
  input  logic              tick,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              convStart,
  output logic              convSel,
  output logic              convActive,
  output logic [DATA_W-1:0] voltResult,
  output logic [DATA_W-1:0] tempResult,
  output logic              updStrobe,
  output logic              updChan
);

  localparam int PERIOD_TICKS = TICK_HZ * PERIOD_SEC;

  dpStrobeT ctl;
  logic     periodHit;

  convsched_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeIn     (modeIn),
    .modeWrite  (modeWrite),
    .convDone   (convDone),
    .periodHit  (periodHit),
    .convStart  (convStart),
    .convSel    (convSel),
    .convActive (convActive),
    .ctl        (ctl)
  );

  convsched_dpath #(
    .DATA_W       (DATA_W),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .tick       (tick),
    .convData   (convData),
    .periodHit  (periodHit),
    .voltResult (voltResult),
    .tempResult (tempResult),
    .updStrobe  (updStrobe),
    .updChan    (updChan)
  );

endmodule

// File: rtl/convsched_checker.sv
module convsched_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic              convSel,
  input logic              convActive,
  input logic              convDone,
  input logic              updStrobe,
  input logic              updChan,
  input logic [DATA_W-1:0] voltResult,
  input logic [DATA_W-1:0] tempResult
);

  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_start_active_R12: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> convActive);

  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && !convDone) |=> !convStart);

  assert_upd_follows_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> ($past(convDone) && $past(convActive)));

  assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && convDone) |=> updStrobe ##1 (!updStrobe || $past(convDone)));

  assert_volt_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(updStrobe && !updChan) |-> $stable(voltResult));

  assert_temp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(updStrobe && updChan) |-> $stable(tempResult));

  assert_sleep_after_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && convDone) |=> (!convActive || (convStart && convSel)));

endmodule

bind conv_scheduler convsched_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_conv_scheduler.sv
module test_conv_scheduler;

  localparam int DATA_W = 16;
  localparam int PERIOD = 64;   // 32 ticks per second, 2 s

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic modeWrite = 1'b0;
  logic tick = 1'b0;
  logic convDone = 1'b0;
  logic [DATA_W-1:0] convData = '0;
  logic convStart, convSel, convActive, updStrobe, updChan;
  logic [DATA_W-1:0] voltResult, tempResult;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  conv_scheduler i_conv_scheduler (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeWrite(modeWrite), .tick(tick),
    .convDone(convDone), .convData(convData), .convStart(convStart), .convSel(convSel),
    .convActive(convActive), .voltResult(voltResult), .tempResult(tempResult),
    .updStrobe(updStrobe), .updChan(updChan)
  );

  // {mode, data}: manual writes; mode 01 = temperature, 10 = voltage
  localparam logic [17:0] VEC [6] = '{
    {2'b10, 16'h1234}, {2'b01, 16'hABCD}, {2'b10, 16'h0000},
    {2'b10, 16'hFFFF}, {2'b01, 16'h8001}, {2'b01, 16'h7FFE}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeMode(input logic [1:0] m);
    modeIn = m; modeWrite = 1'b1;
    step();
    modeWrite = 1'b0;
  endtask

  task automatic finishConv(input logic [DATA_W-1:0] d);
    convDone = 1'b1; convData = d;
    step();
    convDone = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] vKeep, tKeep;
    bit sawStart;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk(!convStart && !convActive && !updStrobe, "R1 idle outputs", {convStart, convActive, updStrobe}, 0);
    chk(voltResult == 0 && tempResult == 0, "R1 results", {voltResult, tempResult}, 0);

    // R2: sleep mode ignores ticks
    sawStart = 0;
    for (int i = 0; i < 2 * PERIOD + 4; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
      if (convStart) sawStart = 1;
    end
    chk(!sawStart, "R2 no start in sleep", sawStart, 0);

    // R8: stray done while idle
    finishConv(16'hDEAD);
    chk(!updStrobe && voltResult == 0 && tempResult == 0, "R8 idle done ignored",
        {updStrobe, voltResult[14:0], tempResult}, 0);

    // table of manual conversions (R3, R4, R5, R9, R10)
    vKeep = '0; tKeep = '0;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] m;
      logic [DATA_W-1:0] d;
      logic expSel;
      m = VEC[i][17:16]; d = VEC[i][15:0]; expSel = (m == 2'b01);
      writeMode(m);
      step();
      chk(convStart && convActive && convSel == expSel,
          (i == 3) ? "R5 rewrite retriggers" : (expSel ? "R4 temp start" : "R3 volt start"),
          {convStart, convActive, convSel}, {2'b11, expSel});
      step();
      chk(!convStart && convActive, "R12 single start", {convStart, convActive}, 2'b01);
      finishConv(d);
      if (expSel) tKeep = d; else vKeep = d;
      chk(updStrobe && updChan == expSel, "R9 strobe tagged", {updStrobe, updChan}, {1'b1, expSel});
      chk(voltResult == vKeep && tempResult == tKeep, "R8 matching register",
          {voltResult, tempResult}, {vKeep, tKeep});
      chk(!convActive && !convStart, "R10 back to sleep", {convActive, convStart}, 0);
      step();
      chk(!updStrobe, "R9 strobe one cycle", updStrobe, 0);
      repeat (4) step();
      chk(!convStart && !convActive, expSel ? "R4 no further start" : "R3 no further start",
          {convStart, convActive}, 0);
    end

    // R6: automatic pair
    writeMode(2'b11);
    step();
    chk(convStart && convSel == 1'b0, "R6 auto volt first", {convStart, convSel}, 2'b10);
    step();
    finishConv(16'h0A0A);
    chk(voltResult == 16'h0A0A && updStrobe && !updChan, "R9 auto volt stored",
        {updStrobe, updChan, voltResult}, {2'b10, 16'h0A0A});
    chk(convStart && convSel == 1'b1 && convActive, "R6 temp follows at once",
        {convStart, convSel, convActive}, 3'b111);
    step();
    finishConv(16'h0B0B);
    chk(tempResult == 16'h0B0B && updChan && !convActive, "R10 auto pair done",
        {convActive, updChan, tempResult}, {2'b01, 16'h0B0B});

    // R7: period of PERIOD ticks
    sawStart = 0;
    for (int i = 0; i < PERIOD - 1; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
      if (convStart) sawStart = 1;
    end
    chk(!sawStart, "R7 no start before period", sawStart, 0);
    tick = 1'b1; step(); tick = 1'b0;
    step();
    chk(convStart && convSel == 1'b0, "R7 pair at period end", {convStart, convSel}, 2'b10);
    step();
    finishConv(16'h1111);
    step();
    finishConv(16'h2222);
    chk(tempResult == 16'h2222 && voltResult == 16'h1111, "R7 second pair stored",
        {voltResult, tempResult}, {16'h1111, 16'h2222});

    // R11: leave auto in the middle of a voltage conversion
    writeMode(2'b00);
    writeMode(2'b11);
    step();
    chk(convStart && convSel == 1'b0, "R11 pair restarted", {convStart, convSel}, 2'b10);
    writeMode(2'b00);
    chk(convActive, "R11 conversion not aborted", convActive, 1);
    finishConv(16'h3C3C);
    chk(voltResult == 16'h3C3C && updStrobe, "R11 result still stored", {updStrobe, voltResult}, {1'b1, 16'h3C3C});
    chk(!convStart && !convActive, "R11 no temp after exit", {convStart, convActive}, 0);
    repeat (4) step();
    chk(!convStart && tempResult == 16'h2222, "R11 temp untouched", {convStart, tempResult}, {1'b0, 16'h2222});

    finished = 1;
    summary();
  end

endmodule